// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits on the write side of a byte-wide parallel flash controller. It watches every bus write and every bus read. It picks out the three-write unlock protocol: key byte 0xAA at the first key address, key byte 0x55 at the second key address, then a command byte at the first key address. From the command byte it drives the mode state of the device. That state covers product-identification mode, requests to arm or disarm software data protection, a chip-erase request, and the two boot-block lockout flags.

Some commands only work when the sequence just before them delivered the prefix command 0x80. The lockout command then expects one parameter write that selects the lower or the upper boot block. While identification mode is active, a small read map returns the vendor code, the device code and the two lockout states.

The block flags, in the same cycle, every write it absorbs as a command or as a lockout parameter, so the program-buffer logic can drop that byte. Every completed command also sends a one-cycle cancel to the page-program engine. The flash array and the timed page-program cycle sit outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, `id_mode`, `lock_lo` and `lock_hi` are 0, and `erase_pulse`, `dp_on_req`, `dp_off_req` and `pgm_cancel` are 0.
- R2: A write of 0xAA at `KEY1_ADDR` (default 0x5555), then a write of 0x55 at `KEY2_ADDR` (default 0x2AAA), then a write at `KEY1_ADDR` completes a command whose code is that last data byte. `cmd_consumed` is high combinationally during that third write only, and low during the two key writes.
- R3: A write with the wrong address or the wrong data at either key step returns the sequencer to idle. In the command step, a write to any address other than `KEY1_ADDR` also returns it to idle; that write is not consumed and has no command effect.
- R4: Command 0x90 sets `id_mode` and command 0xF0 clears it. The change is visible one cycle after the command write.
- R5: While `id_mode` is 1, `id_rdata` follows `addr` combinationally: offset 0 gives 0x1F, offset 1 gives 0xA4, offset 2 gives 0xFF when `lock_lo` is set and 0xFE otherwise, and offset top-minus-13 (0x7FFF2 by default) gives the same encoding for `lock_hi`. Every other offset gives 0. While `id_mode` is 0, `id_rdata` is 0.
- R6: Command 0x80 only sets a prefix flag. Commands 0x10, 0x20 and 0x40 act only when the sequence completed just before them was a 0x80 command. Without that prefix they are still consumed but have no effect.
- R7: Command 0xA0, with no prefix needed, gives a one-cycle `dp_on_req`. Command 0x20 after the prefix gives a one-cycle `dp_off_req`.
- R8: Command 0x10 after the prefix gives a one-cycle `erase_pulse` in the cycle after the write. It is refused, with no pulse, while `lock_lo` or `lock_hi` is set.
- R9: After command 0x40 with the prefix, the next write is a lockout parameter. Data 0x00 at address 0 sets `lock_lo`, and data 0xFF at the all-ones address sets `lock_hi`; such a write is consumed. Any other write drops the pending parameter and is then handled as an ordinary write by the unlock sequencer.
- R10: A read (`rd_en` with no `wr_en`) returns the sequencer to idle and clears the prefix flag.
- R11: Every completed command, whatever its code, gives a one-cycle `pgm_cancel` in the cycle after the command write.
- R12: `lock_lo` and `lock_hi`, once set, stay set until reset; no command clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address of the current access |
| wdata | input | 8 | Write data |
| cmd_consumed | output | 1 | The current write is a command or lockout parameter and must not be stored |
| id_rdata | output | 8 | Identification read data, valid while `id_mode` is 1 |
| id_mode | output | 1 | Product-identification mode active |
| lock_lo | output | 1 | Lower boot block locked |
| lock_hi | output | 1 | Upper boot block locked |
| erase_pulse | output | 1 | One-cycle chip-erase request to the array controller |
| dp_on_req | output | 1 | One-cycle request to arm data-protect enable |
| dp_off_req | output | 1 | One-cycle request to arm data-protect disable |
| pgm_cancel | output | 1 | One-cycle cancel of any pending page-program operation |

## Verification
The bench builds the block with its default parameters: a 19-bit address, key addresses 0x5555 and 0x2AAA, and ID codes 0x1F and 0xA4. With these values both lockout parameter addresses, 0 and 0x7FFFF, can be reached, and so can the upper-lockout ID offset 0x7FFF2, so the bench checks the real corner addresses rather than scaled-down ones. The directed scenarios cover the prefix rules, since the prefix must come from the immediately preceding sequence. They also cover a sequence aborted by a read and a wrong lockout parameter that must fall through into a fresh unlock sequence.

// File: rtl/flash_cmd_pkg.sv
// Package: shared types and command codes for the flash command sequencer.
// Assumes byte-wide data; the codes are fixed by the bus protocol.
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_KEY1 = 2'd1,
        SEQ_KEY2 = 2'd2
    } seq_state_t;

    localparam logic [7:0] KEY1_DATA = 8'hAA;
    localparam logic [7:0] KEY2_DATA = 8'h55;

    localparam logic [7:0] OP_PREFIX = 8'h80;
    localparam logic [7:0] OP_ERASE  = 8'h10;
    localparam logic [7:0] OP_DP_OFF = 8'h20;
    localparam logic [7:0] OP_LOCK   = 8'h40;
    localparam logic [7:0] OP_ID_IN  = 8'h90;
    localparam logic [7:0] OP_DP_ON  = 8'hA0;
    localparam logic [7:0] OP_ID_OUT = 8'hF0;

    // Decoded effect of a completed command, after the prefix rule.
    typedef struct packed {
        logic erase;
        logic dp_on;
        logic dp_off;
        logic lock_arm;
        logic id_in;
        logic id_out;
    } cmd_hits_t;

endpackage

// File: rtl/fcs_unlock_fsm.sv
// Module: three-write unlock sequencer with prefix flag.
// Tracks the key writes and fires on the command write at KEY1_ADDR.
// Assumes wr_en and rd_en are one-cycle strobes; a write wins over a read.
// hold_i marks a write already taken as a lockout parameter; the FSM ignores it.
module fcs_unlock_fsm
    import flash_cmd_pkg::*;
#(
    parameter int               ADDR_W    = 19,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = ADDR_W'(32'h5555),
    parameter logic [ADDR_W-1:0] KEY2_ADDR = ADDR_W'(32'h2AAA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              hold_i,
    output logic              cmd_fire_o,
    output logic              prefixed_o
);

    seq_state_t state_q;
    logic       prefix_q;
    logic       wr_live;
    logic       at_key1;
    logic       at_key2;

    // Purpose: qualify the current write and compare addresses once.
    always_comb begin
        wr_live = wr_en && !hold_i;
        at_key1 = (addr == KEY1_ADDR);
        at_key2 = (addr == KEY2_ADDR);
    end

    // Purpose: flag the write that delivers a command byte.
    always_comb begin
        cmd_fire_o = wr_live && (state_q == SEQ_KEY2) && at_key1;
        prefixed_o = prefix_q;
    end

    // Purpose: advance, abort or complete the unlock sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            prefix_q <= 1'b0;
        end else if (wr_live) begin
            case (state_q)
                SEQ_IDLE: begin
                    if (at_key1 && wdata == KEY1_DATA) begin
                        state_q <= SEQ_KEY1;
                    end else begin
                        state_q  <= SEQ_IDLE;
                        prefix_q <= 1'b0;
                    end
                end
                SEQ_KEY1: begin
                    if (at_key2 && wdata == KEY2_DATA) begin
                        state_q <= SEQ_KEY2;
                    end else begin
                        state_q  <= SEQ_IDLE;
                        prefix_q <= 1'b0;
                    end
                end
                SEQ_KEY2: begin
                    state_q <= SEQ_IDLE;
                    if (at_key1) begin
                        prefix_q <= (wdata == OP_PREFIX);
                    end else begin
                        prefix_q <= 1'b0;
                    end
                end
                default: begin
                    state_q  <= SEQ_IDLE;
                    prefix_q <= 1'b0;
                end
            endcase
        end else if (rd_en && !wr_en) begin
            state_q  <= SEQ_IDLE;
            prefix_q <= 1'b0;
        end
    end

endmodule

// File: rtl/fcs_cmd_decode.sv
// Module: decodes a completed command byte into effects.
// Applies the prefix rule: erase, data-protect disable and lockout arm
// need the prefix flag. Purely combinational.
module fcs_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic       cmd_fire_i,
    input  logic       prefixed_i,
    input  logic [7:0] code_i,
    output cmd_hits_t  hits_o
);

    // Purpose: map the command code to its effect for this cycle.
    always_comb begin
        hits_o = '0;
        if (cmd_fire_i) begin
            case (code_i)
                OP_ERASE:  hits_o.erase    = prefixed_i;
                OP_DP_OFF: hits_o.dp_off   = prefixed_i;
                OP_LOCK:   hits_o.lock_arm = prefixed_i;
                OP_DP_ON:  hits_o.dp_on    = 1'b1;
                OP_ID_IN:  hits_o.id_in    = 1'b1;
                OP_ID_OUT: hits_o.id_out   = 1'b1;
                default:   hits_o          = '0;
            endcase
        end
    end

endmodule

// File: rtl/fcs_mode_regs.sv
// Module: mode state and request pulses.
// Holds the ID mode, the lockout flags and the pending lockout parameter,
// and registers one-cycle requests. Assumes one write per wr_en strobe.
// The all-ones address and address 0 are the lockout parameter targets.
module fcs_mode_regs
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              cmd_fire_i,
    input  cmd_hits_t         hits_i,
    output logic              param_take_o,
    output logic              id_mode_o,
    output logic              lock_lo_o,
    output logic              lock_hi_o,
    output logic              erase_pulse_o,
    output logic              dp_on_req_o,
    output logic              dp_off_req_o,
    output logic              pgm_cancel_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOT_ADDR = '0;

    logic param_pend_q;
    logic take_lo;
    logic take_hi;
    logic erase_ok;

    // Purpose: recognise a valid lockout parameter write.
    always_comb begin
        take_lo      = wr_en && param_pend_q && (addr == BOT_ADDR) && (wdata == 8'h00);
        take_hi      = wr_en && param_pend_q && (addr == TOP_ADDR) && (wdata == 8'hFF);
        param_take_o = take_lo || take_hi;
        erase_ok     = hits_i.erase && !lock_lo_o && !lock_hi_o;
    end

    // Purpose: pending parameter lives for exactly one following write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            param_pend_q <= 1'b0;
        end else if (wr_en) begin
            param_pend_q <= hits_i.lock_arm;
        end
    end

    // Purpose: sticky lockout flags, set only by a parameter write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_lo_o <= 1'b0;
            lock_hi_o <= 1'b0;
        end else begin
            if (take_lo) begin
                lock_lo_o <= 1'b1;
            end
            if (take_hi) begin
                lock_hi_o <= 1'b1;
            end
        end
    end

    // Purpose: product-identification mode entry and exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_mode_o <= 1'b0;
        end else if (hits_i.id_in) begin
            id_mode_o <= 1'b1;
        end else if (hits_i.id_out) begin
            id_mode_o <= 1'b0;
        end
    end

    // Purpose: one-cycle requests to the array and program engines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_pulse_o <= 1'b0;
            dp_on_req_o   <= 1'b0;
            dp_off_req_o  <= 1'b0;
            pgm_cancel_o  <= 1'b0;
        end else begin
            erase_pulse_o <= erase_ok;
            dp_on_req_o   <= hits_i.dp_on;
            dp_off_req_o  <= hits_i.dp_off;
            pgm_cancel_o  <= cmd_fire_i;
        end
    end

endmodule

// File: rtl/fcs_id_map.sv
// Module: product-identification read map, combinational.
// Returns codes only while ID mode is on and 0 otherwise.
// The upper lockout status sits 13 below the all-ones address.
module fcs_id_map #(
    parameter int         ADDR_W   = 19,
    parameter logic [7:0] VENDOR_ID = 8'h1F,
    parameter logic [7:0] DEVICE_ID = 8'hA4
) (
    input  logic              id_mode_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock_lo_i,
    input  logic              lock_hi_i,
    output logic [7:0]        rdata_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR   = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] HI_ID_ADDR = TOP_ADDR - ADDR_W'(13);

    // Purpose: select the identification byte for the current address.
    always_comb begin
        rdata_o = 8'h00;
        if (id_mode_i) begin
            if (addr == ADDR_W'(0)) begin
                rdata_o = VENDOR_ID;
            end else if (addr == ADDR_W'(1)) begin
                rdata_o = DEVICE_ID;
            end else if (addr == ADDR_W'(2)) begin
                rdata_o = {7'h7F, lock_lo_i};
            end else if (addr == HI_ID_ADDR) begin
                rdata_o = {7'h7F, lock_hi_i};
            end
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Module: top of the flash command sequencer.
// Connects the unlock FSM, the command decoder, the mode registers and the
// ID read map. cmd_consumed is combinational so the program buffer can drop
// the byte in the same cycle as the write.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int               ADDR_W    = 19,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = ADDR_W'(32'h5555),
    parameter logic [ADDR_W-1:0] KEY2_ADDR = ADDR_W'(32'h2AAA),
    parameter logic [7:0]        VENDOR_ID = 8'h1F,
    parameter logic [7:0]        DEVICE_ID = 8'hA4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              cmd_consumed,
    output logic [7:0]        id_rdata,
    output logic              id_mode,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              erase_pulse,
    output logic              dp_on_req,
    output logic              dp_off_req,
    output logic              pgm_cancel
);

    logic      cmd_fire;
    logic      prefixed;
    logic      param_take;
    cmd_hits_t hits;

    fcs_unlock_fsm #(
        .ADDR_W    (ADDR_W),
        .KEY1_ADDR (KEY1_ADDR),
        .KEY2_ADDR (KEY2_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .hold_i     (param_take),
        .cmd_fire_o (cmd_fire),
        .prefixed_o (prefixed)
    );

    fcs_cmd_decode u_dec (
        .cmd_fire_i (cmd_fire),
        .prefixed_i (prefixed),
        .code_i     (wdata),
        .hits_o     (hits)
    );

    fcs_mode_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .cmd_fire_i    (cmd_fire),
        .hits_i        (hits),
        .param_take_o  (param_take),
        .id_mode_o     (id_mode),
        .lock_lo_o     (lock_lo),
        .lock_hi_o     (lock_hi),
        .erase_pulse_o (erase_pulse),
        .dp_on_req_o   (dp_on_req),
        .dp_off_req_o  (dp_off_req),
        .pgm_cancel_o  (pgm_cancel)
    );

    fcs_id_map #(
        .ADDR_W    (ADDR_W),
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_id (
        .id_mode_i (id_mode),
        .addr      (addr),
        .lock_lo_i (lock_lo),
        .lock_hi_i (lock_hi),
        .rdata_o   (id_rdata)
    );

    // Purpose: tell the program buffer to drop command and parameter bytes.
    always_comb begin
        cmd_consumed = cmd_fire || param_take;
    end

endmodule

// File: rtl/fcs_checker.sv
// Module: assertion checker for flash_cmd_seq, attached by bind.
// Observes ports only.
module fcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       cmd_consumed,
    input logic [7:0] id_rdata,
    input logic       id_mode,
    input logic       lock_lo,
    input logic       lock_hi,
    input logic       erase_pulse,
    input logic       dp_on_req,
    input logic       dp_off_req,
    input logic       pgm_cancel
);

    AST_CONSUMED_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_consumed |-> wr_en); // R2

    AST_ID_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> id_rdata == 8'h00); // R5

    AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |=> !erase_pulse); // R8

    AST_ERASE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |-> (!lock_lo && !lock_hi)); // R8

    AST_DP_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_pulse, dp_on_req, dp_off_req})); // R7

    AST_REQ_CANCELS_PGM: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_pulse || dp_on_req || dp_off_req) |-> pgm_cancel); // R11

    AST_READ_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> !pgm_cancel); // R10

    AST_LOCK_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lo |=> lock_lo); // R12

    AST_LOCK_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hi |=> lock_hi); // R12

endmodule

bind flash_cmd_seq fcs_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .cmd_consumed (cmd_consumed),
    .id_rdata     (id_rdata),
    .id_mode      (id_mode),
    .lock_lo      (lock_lo),
    .lock_hi      (lock_hi),
    .erase_pulse  (erase_pulse),
    .dp_on_req    (dp_on_req),
    .dp_off_req   (dp_off_req),
    .pgm_cancel   (pgm_cancel)
);

// File: tb/flash_cmd_seq_tb.sv
// Directed bench for flash_cmd_seq: one task per scenario.
module flash_cmd_seq_tb;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 19;
    localparam logic [ADDR_W-1:0] K1  = 19'h05555;
    localparam logic [ADDR_W-1:0] K2  = 19'h02AAA;
    localparam logic [ADDR_W-1:0] TOP = 19'h7FFFF;
    localparam logic [ADDR_W-1:0] HID = 19'h7FFF2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              cmd_consumed;
    logic [7:0]        id_rdata;
    logic              id_mode, lock_lo, lock_hi;
    logic              erase_pulse, dp_on_req, dp_off_req, pgm_cancel;

    int n_chk  = 0;
    int n_fail = 0;

    logic       got_cons;
    logic       got_erase, got_on, got_off, got_cancel;
    logic [7:0] got_rd;

    flash_cmd_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cmd_consumed(cmd_consumed),
        .id_rdata(id_rdata), .id_mode(id_mode), .lock_lo(lock_lo),
        .lock_hi(lock_hi), .erase_pulse(erase_pulse), .dp_on_req(dp_on_req),
        .dp_off_req(dp_off_req), .pgm_cancel(pgm_cancel)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write; consumed sampled mid-cycle, registered outputs after the edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        #(CLK_P/4);
        got_cons = cmd_consumed;
        @(negedge clk);
        wr_en = 1'b0;
        got_erase = erase_pulse; got_on = dp_on_req;
        got_off = dp_off_req; got_cancel = pgm_cancel;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #(CLK_P/4);
        got_rd = id_rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic seq(input logic [7:0] code);
        wr(K1, 8'hAA);
        wr(K2, 8'h55);
        wr(K1, code);
    endtask

    task automatic t_reset();
        check("R1 id_mode", {7'd0, id_mode}, 8'd0);
        check("R1 lock_lo", {7'd0, lock_lo}, 8'd0);
        check("R1 lock_hi", {7'd0, lock_hi}, 8'd0);
        check("R1 pulses", {4'd0, erase_pulse, dp_on_req, dp_off_req, pgm_cancel}, 8'd0);
    endtask

    task automatic t_unlock();
        wr(K1, 8'hAA);
        check("R2 key1 not consumed", {7'd0, got_cons}, 8'd0);
        wr(K2, 8'h55);
        check("R2 key2 not consumed", {7'd0, got_cons}, 8'd0);
        wr(K1, 8'h90);
        check("R2 command consumed", {7'd0, got_cons}, 8'd1);
        check("R11 cancel on command", {7'd0, got_cancel}, 8'd1);
        check("R4 id entry", {7'd0, id_mode}, 8'd1);
    endtask

    task automatic t_id_map();
        rd(19'h0); check("R5 vendor", got_rd, 8'h1F);
        rd(19'h1); check("R5 device", got_rd, 8'hA4);
        rd(19'h2); check("R5 lower status", got_rd, 8'hFE);
        rd(HID);   check("R5 upper status", got_rd, 8'hFE);
        rd(19'h5); check("R5 other offset", got_rd, 8'h00);
        seq(8'hF0);
        check("R4 id exit", {7'd0, id_mode}, 8'd0);
        rd(19'h0); check("R5 outside id mode", got_rd, 8'h00);
    endtask

    task automatic t_abort();
        wr(K1, 8'hAA); wr(K2, 8'h54); wr(K1, 8'h90);
        check("R3 bad key2 not consumed", {7'd0, got_cons}, 8'd0);
        check("R3 bad key2 no id", {7'd0, id_mode}, 8'd0);
        wr(K1, 8'hAA); wr(K2, 8'h55); wr(19'h01234, 8'h90);
        check("R3 wrong cmd addr not consumed", {7'd0, got_cons}, 8'd0);
        check("R3 wrong cmd addr no cancel", {7'd0, got_cancel}, 8'd0);
        check("R3 wrong cmd addr no id", {7'd0, id_mode}, 8'd0);
    endtask

    task automatic t_prefix();
        seq(8'h10);
        check("R6 erase w/o prefix consumed", {7'd0, got_cons}, 8'd1);
        check("R6 erase w/o prefix ignored", {7'd0, got_erase}, 8'd0);
        seq(8'h20);
        check("R6 dp off w/o prefix ignored", {7'd0, got_off}, 8'd0);
        seq(8'h80); seq(8'h10);
        check("R8 erase pulse", {7'd0, got_erase}, 8'd1);
        @(negedge clk);
        check("R8 erase one cycle", {7'd0, erase_pulse}, 8'd0);
        seq(8'hA0);
        check("R7 dp on req", {7'd0, got_on}, 8'd1);
        seq(8'h80); seq(8'h20);
        check("R7 dp off req", {7'd0, got_off}, 8'd1);
        seq(8'h80); seq(8'h90); seq(8'h10);
        check("R6 prefix not adjacent", {7'd0, got_erase}, 8'd0);
        seq(8'hF0);
    endtask

    task automatic t_read_cancel();
        wr(K1, 8'hAA); wr(K2, 8'h55); rd(19'h0); wr(K1, 8'h90);
        check("R10 read aborts sequence", {7'd0, got_cons}, 8'd0);
        check("R10 read aborts no id", {7'd0, id_mode}, 8'd0);
        seq(8'h80); rd(19'h0); seq(8'h10);
        check("R10 read clears prefix", {7'd0, got_erase}, 8'd0);
    endtask

    task automatic t_lockout();
        seq(8'h80); seq(8'h40);
        wr(19'h00100, 8'h00);
        check("R9 wrong param not consumed", {7'd0, got_cons}, 8'd0);
        wr(19'h0, 8'h00);
        check("R9 param dropped", {7'd0, lock_lo}, 8'd0);
        seq(8'h80); seq(8'h40); seq(8'h90);
        check("R9 fallthrough unlocks", {7'd0, id_mode}, 8'd1);
        seq(8'hF0);
        seq(8'h80); seq(8'h40); wr(19'h0, 8'h00);
        check("R9 lower param consumed", {7'd0, got_cons}, 8'd1);
        check("R9 lock_lo set", {7'd0, lock_lo}, 8'd1);
        seq(8'h80); seq(8'h10);
        check("R8 erase refused when locked", {7'd0, got_erase}, 8'd0);
        seq(8'h80); seq(8'h40); wr(TOP, 8'hFF);
        check("R9 upper param consumed", {7'd0, got_cons}, 8'd1);
        check("R9 lock_hi set", {7'd0, lock_hi}, 8'd1);
        seq(8'h90);
        rd(19'h2); check("R5 lower locked status", got_rd, 8'hFF);
        rd(HID);   check("R5 upper locked status", got_rd, 8'hFF);
        seq(8'hF0); seq(8'hA0); seq(8'h80); seq(8'h20);
        check("R12 lock_lo sticky", {7'd0, lock_lo}, 8'd1);
        check("R12 lock_hi sticky", {7'd0, lock_hi}, 8'd1);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unlock();
        t_id_map();
        t_abort();
        t_prefix();
        t_read_cancel();
        t_lockout();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule